// File: doc/BRIEF.md
# Enciphered Instruction Search Sequencer

This block is a test-harness controller placed in the external bus path of a processor whose program memory is enciphered on the bus. It runs repeated trials. In each trial it holds the processor in reset and releases it. It counts bus strobes from the release up to a chosen fetch and then drives its own ciphertext bytes onto the bus in place of the fetched ones. It then watches an output port for a few more strobes. Because every trial starts from reset and every count is fixed, each trial meets the processor in the same state.

The goal is to find the ciphertext of a known three-byte port-write instruction: opcode 75h, port address 90h, immediate operand. The sequencer walks through candidate values for the first two substituted bytes, starting from a seed. It accepts a candidate once two different operand values give two different port readings. With the pair found, it tries all 256 operand ciphertexts and writes each port reading into a 256-entry result table, indexed by the operand ciphertext. That table is the decryption of the operand address.

An optional one-byte side-effect-free prefix moves the probe one address later. A host that already knows the opcode and port-address ciphertexts for the later addresses supplies them as the seed, so the next address can be tabulated at once.

Top module: `cipher_probe_seq`

## Requirements
- R1: While `rst` is high and in the cycle after it, `cpu_rst_o` is 1, and `ovr_en_o`, `tbl_we_o`, `done_o` and `ok_o` are 0.
- R2: Between two trials of one run, `cpu_rst_o` stays high for exactly RST_CYC+2 clocks (RST_CYC of hold plus two of turnaround). While it is low, exactly TGT_IDX+N+OBS_CYC bus strobes are accepted, where N is 3 without a prefix and 4 with one. It rises in the clock after the last of those strobes.
- R3: Bus strobes are numbered from 0 starting at each reset release. `ovr_en_o` is high on strobes TGT_IDX to TGT_IDX+N-1 and low on every other strobe.
- R4: The substituted bytes come in this order: candidate pair bits 15:8, then bits 7:0, then the operand byte.
- R5: A trial hits when, while `cpu_rst_o` is low, `port_val_i` differs from PORT_RST (default FFh). The first differing value is the trial's result. A trial with no hit has the result PORT_RST.
- R6: The search starts at `seed_i`. Each pair is first tried with operand 00h. Only after a hit is it tried again with operand 01h. The pair is accepted only if both trials hit with different results. Otherwise the next pair (pair+1) is tried with operand 00h.
- R7: If pair FFFFh is rejected, the run ends with `done_o`=1 and `ok_o`=0, and no table write is made.
- R8: After acceptance, 256 trials use operands 00h..FFh in ascending order. After each trial there is one `tbl_we_o` pulse, with `tbl_addr_o` set to the operand and `tbl_data_o` set to the trial result. After the last write, `done_o`=1 and `ok_o`=1.
- R9: With `pfx_en_i` high at start, `pfx_byte_i` is substituted first, on strobe TGT_IDX, and the R4 bytes follow one strobe later each.
- R10: `start_i` is ignored while a run is in progress. `done_o` stays high until the next `start_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a run (sampled when idle or done) |
| seed_i | input | 16 | First candidate pair |
| pfx_en_i | input | 1 | Insert prefix byte before the probe |
| pfx_byte_i | input | 8 | Ciphertext of the side-effect-free prefix |
| bus_cyc_i | input | 1 | One-clock strobe per processor bus fetch |
| port_val_i | input | 8 | Monitored output port value |
| cpu_rst_o | output | 1 | Reset to the processor under test |
| ovr_en_o | output | 1 | Replace the fetched byte on this strobe |
| ovr_data_o | output | 8 | Replacement byte |
| tbl_we_o | output | 1 | Result table write strobe |
| tbl_addr_o | output | 8 | Table index (operand ciphertext) |
| tbl_data_o | output | 8 | Observed plaintext |
| done_o | output | 1 | Run finished |
| ok_o | output | 1 | A pair was found and the table is complete |

## Verification
The end of a trial, where the result is judged and the next trial is launched, can fall in the same clock as a fresh `start_i` from the host. The bench holds `start_i` high with a different seed for several hundred clocks in the middle of tabulation, across many trial boundaries. It then judges that the table addresses still rise one by one, that every table value still matches the expected decryption, and that the reset gaps between trials keep their exact length. A decoy candidate whose port reading is the same for both operands tests the accept rule against a plain hit.

// File: rtl/probe_seq_pkg.sv
package probe_seq_pkg;
  typedef enum logic [1:0] {TM_IDLE, TM_RST, TM_RUN} tm_st_e;
  typedef enum logic [2:0] {SQ_IDLE, SQ_TRY_A, SQ_TRY_B, SQ_TABLE, SQ_DONE} sq_st_e;
  localparam logic [7:0] OPND_A = 8'h00;
  localparam logic [7:0] OPND_B = 8'h01;
endpackage

// File: rtl/trial_timer.sv
module trial_timer
  import probe_seq_pkg::*;
#(
  parameter int RST_CYC = 16,
  parameter int TGT_IDX = 8,
  parameter int OBS_CYC = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        go_i,
  input  logic        bus_cyc_i,
  input  logic        long_i,
  input  logic [31:0] bytes_i,
  output logic        cpu_rst_o,
  output logic        ovr_en_o,
  output logic [7:0]  ovr_data_o,
  output logic        end_o
);
  localparam int RW = $clog2(RST_CYC + 1);
  localparam int BW = $clog2(TGT_IDX + OBS_CYC + 6);

  tm_st_e          st, st_nx;
  logic [RW-1:0]   rcnt;
  logic [BW-1:0]   bcnt, bcnt_nx, last, rel;
  logic            end_nx, win;
  logic [1:0]      slot;

  always_comb begin
    st_nx   = st;
    bcnt_nx = bcnt;
    end_nx  = 1'b0;
    last    = BW'(TGT_IDX + OBS_CYC + 2) + BW'(long_i);
    case (st)
      TM_IDLE: if (go_i) begin st_nx = TM_RST; bcnt_nx = '0; end
      TM_RST:  if (rcnt == RW'(RST_CYC - 1)) begin st_nx = TM_RUN; bcnt_nx = '0; end
      TM_RUN: begin
        if (bus_cyc_i) begin
          if (bcnt == last) begin
            st_nx  = TM_IDLE;
            end_nx = 1'b1;
          end else begin
            bcnt_nx = bcnt + 1'b1;
          end
        end
      end
      default: st_nx = TM_IDLE;
    endcase
    rel  = bcnt_nx - BW'(TGT_IDX);
    win  = (st_nx == TM_RUN) && (bcnt_nx >= BW'(TGT_IDX)) &&
           (rel < (BW'(3) + BW'(long_i)));
    slot = rel[1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= TM_IDLE;
      rcnt       <= '0;
      bcnt       <= '0;
      cpu_rst_o  <= 1'b1;
      ovr_en_o   <= 1'b0;
      ovr_data_o <= '0;
      end_o      <= 1'b0;
    end else begin
      st         <= st_nx;
      rcnt       <= (st == TM_RST) ? rcnt + 1'b1 : '0;
      bcnt       <= bcnt_nx;
      cpu_rst_o  <= (st_nx != TM_RUN);
      ovr_en_o   <= win;
      ovr_data_o <= win ? bytes_i[slot*8 +: 8] : 8'h00;
      end_o      <= end_nx;
    end
  end
endmodule

// File: rtl/search_ctl.sv
module search_ctl
  import probe_seq_pkg::*;
#(
  parameter logic [7:0] PORT_RST = 8'hFF
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start_i,
  input  logic [15:0] seed_i,
  input  logic        pfx_en_i,
  input  logic [7:0]  pfx_byte_i,
  input  logic [7:0]  port_val_i,
  input  logic        cpu_rst_i,
  input  logic        end_i,
  output logic        go_o,
  output logic        long_o,
  output logic [31:0] bytes_o,
  output logic        tbl_we_o,
  output logic [7:0]  tbl_addr_o,
  output logic [7:0]  tbl_data_o,
  output logic        done_o,
  output logic        ok_o
);
  sq_st_e      st;
  logic [15:0] pair;
  logic [7:0]  opnd, v0, hval, pfx_b, cur_op;
  logic        hit;

  always_comb begin
    case (st)
      SQ_TRY_A: cur_op = OPND_A;
      SQ_TRY_B: cur_op = OPND_B;
      default:  cur_op = opnd;
    endcase
    if (long_o) bytes_o = {cur_op, pair[7:0], pair[15:8], pfx_b};
    else        bytes_o = {8'h00, cur_op, pair[7:0], pair[15:8]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= SQ_IDLE; pair <= '0; opnd <= '0; v0 <= '0; hval <= '0;
      pfx_b <= '0; long_o <= 1'b0; hit <= 1'b0; go_o <= 1'b0;
      tbl_we_o <= 1'b0; tbl_addr_o <= '0; tbl_data_o <= '0;
      done_o <= 1'b0; ok_o <= 1'b0;
    end else begin
      go_o     <= 1'b0;
      tbl_we_o <= 1'b0;
      if (!cpu_rst_i && !hit && port_val_i != PORT_RST) begin
        hit  <= 1'b1;
        hval <= port_val_i;
      end
      case (st)
        SQ_IDLE, SQ_DONE: begin
          if (start_i) begin
            pair <= seed_i; long_o <= pfx_en_i; pfx_b <= pfx_byte_i;
            st <= SQ_TRY_A; go_o <= 1'b1; hit <= 1'b0;
            done_o <= 1'b0; ok_o <= 1'b0;
          end
        end
        SQ_TRY_A: if (end_i) begin
          hit <= 1'b0;
          if (hit) begin
            v0 <= hval; st <= SQ_TRY_B; go_o <= 1'b1;
          end else if (pair == 16'hFFFF) begin
            st <= SQ_DONE; done_o <= 1'b1;
          end else begin
            pair <= pair + 1'b1; go_o <= 1'b1;
          end
        end
        SQ_TRY_B: if (end_i) begin
          hit <= 1'b0;
          if (hit && hval != v0) begin
            st <= SQ_TABLE; opnd <= '0; go_o <= 1'b1;
          end else if (pair == 16'hFFFF) begin
            st <= SQ_DONE; done_o <= 1'b1;
          end else begin
            pair <= pair + 1'b1; st <= SQ_TRY_A; go_o <= 1'b1;
          end
        end
        SQ_TABLE: if (end_i) begin
          hit        <= 1'b0;
          tbl_we_o   <= 1'b1;
          tbl_addr_o <= opnd;
          tbl_data_o <= hit ? hval : PORT_RST;
          if (opnd == 8'hFF) begin
            st <= SQ_DONE; done_o <= 1'b1; ok_o <= 1'b1;
          end else begin
            opnd <= opnd + 1'b1; go_o <= 1'b1;
          end
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cipher_probe_seq.sv
module cipher_probe_seq #(
  parameter int         RST_CYC  = 16,
  parameter int         TGT_IDX  = 8,
  parameter int         OBS_CYC  = 4,
  parameter logic [7:0] PORT_RST = 8'hFF
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start_i,
  input  logic [15:0] seed_i,
  input  logic        pfx_en_i,
  input  logic [7:0]  pfx_byte_i,
  input  logic        bus_cyc_i,
  input  logic [7:0]  port_val_i,
  output logic        cpu_rst_o,
  output logic        ovr_en_o,
  output logic [7:0]  ovr_data_o,
  output logic        tbl_we_o,
  output logic [7:0]  tbl_addr_o,
  output logic [7:0]  tbl_data_o,
  output logic        done_o,
  output logic        ok_o
);
  logic        go, long_sel, trial_end;
  logic [31:0] sub_bytes;

  trial_timer #(.RST_CYC(RST_CYC), .TGT_IDX(TGT_IDX), .OBS_CYC(OBS_CYC)) u_tmr (
    .clk(clk), .rst(rst), .go_i(go), .bus_cyc_i(bus_cyc_i), .long_i(long_sel),
    .bytes_i(sub_bytes), .cpu_rst_o(cpu_rst_o), .ovr_en_o(ovr_en_o),
    .ovr_data_o(ovr_data_o), .end_o(trial_end)
  );

  search_ctl #(.PORT_RST(PORT_RST)) u_ctl (
    .clk(clk), .rst(rst), .start_i(start_i), .seed_i(seed_i),
    .pfx_en_i(pfx_en_i), .pfx_byte_i(pfx_byte_i), .port_val_i(port_val_i),
    .cpu_rst_i(cpu_rst_o), .end_i(trial_end), .go_o(go), .long_o(long_sel),
    .bytes_o(sub_bytes), .tbl_we_o(tbl_we_o), .tbl_addr_o(tbl_addr_o),
    .tbl_data_o(tbl_data_o), .done_o(done_o), .ok_o(ok_o)
  );
endmodule

// File: rtl/probe_seq_chk.sv
module probe_seq_chk #(
  parameter int RST_CYC = 16
) (
  input logic clk,
  input logic rst,
  input logic start_i,
  input logic cpu_rst_o,
  input logic ovr_en_o,
  input logic tbl_we_o,
  input logic done_o,
  input logic ok_o
);
  logic [15:0] hold_cnt;

  always_ff @(posedge clk) begin
    if (rst) hold_cnt <= '0;
    else if (cpu_rst_o) hold_cnt <= (hold_cnt == 16'hFFFF) ? hold_cnt : hold_cnt + 1'b1;
    else hold_cnt <= '0;
  end

  p_ovr_out_of_reset_r3: assert property (@(posedge clk) disable iff (rst)
    ovr_en_o |-> !cpu_rst_o);

  p_rst_hold_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(cpu_rst_o) |-> hold_cnt >= 16'(RST_CYC));

  p_tbl_between_trials_r8: assert property (@(posedge clk) disable iff (rst)
    tbl_we_o |-> cpu_rst_o);

  p_ok_with_done_r7: assert property (@(posedge clk) disable iff (rst)
    ok_o |-> done_o);

  p_done_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    done_o && !start_i |=> done_o);

  p_quiet_when_done_r10: assert property (@(posedge clk) disable iff (rst)
    done_o |-> cpu_rst_o && !ovr_en_o);
endmodule

bind cipher_probe_seq probe_seq_chk #(.RST_CYC(RST_CYC)) u_chk (
  .clk(clk), .rst(rst), .start_i(start_i), .cpu_rst_o(cpu_rst_o),
  .ovr_en_o(ovr_en_o), .tbl_we_o(tbl_we_o), .done_o(done_o), .ok_o(ok_o)
);

// File: tb/sim_cipher_probe_seq.sv
module sim_cipher_probe_seq;
  localparam int CLK_NS  = 10;
  localparam int RST_CYC = 16;
  localparam int TGT     = 8;
  localparam int OBS     = 4;

  logic clk = 1'b0, rst = 1'b1, start_i = 1'b0, pfx_en_i = 1'b0;
  logic [15:0] seed_i = '0;
  logic [7:0]  pfx_byte_i = '0;
  logic        bus_cyc_i = 1'b0;
  logic [7:0]  port_val_i = 8'hFF;
  logic cpu_rst_o, ovr_en_o, tbl_we_o, done_o, ok_o;
  logic [7:0] ovr_data_o, tbl_addr_o, tbl_data_o;

  int checks = 0, errors = 0;

  always #(CLK_NS/2) clk = ~clk;

  cipher_probe_seq #(.RST_CYC(RST_CYC), .TGT_IDX(TGT), .OBS_CYC(OBS)) u0 (
    .clk(clk), .rst(rst), .start_i(start_i), .seed_i(seed_i), .pfx_en_i(pfx_en_i),
    .pfx_byte_i(pfx_byte_i), .bus_cyc_i(bus_cyc_i), .port_val_i(port_val_i),
    .cpu_rst_o(cpu_rst_o), .ovr_en_o(ovr_en_o), .ovr_data_o(ovr_data_o),
    .tbl_we_o(tbl_we_o), .tbl_addr_o(tbl_addr_o), .tbl_data_o(tbl_data_o),
    .done_o(done_o), .ok_o(ok_o)
  );

  function automatic logic [7:0] key(input int a);
    return 8'h75 ^ 8'((a - TGT) * 147);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // processor under test: enciphered fetches, strobe every other clock
  int bidx = 0, ds = 0, pend_at = -1;
  logic [7:0] pend_val = '0;
  always @(posedge clk) begin
    logic [7:0] f, p;
    if (cpu_rst_o) begin
      bidx = 0; ds = 0; pend_at = -1;
      bus_cyc_i  <= 1'b0;
      port_val_i <= 8'hFF;
    end else begin
      bus_cyc_i <= ~bus_cyc_i;
      if (bus_cyc_i) begin
        f = ovr_en_o ? ovr_data_o : 8'hCC;
        p = f ^ key(bidx);
        case (ds)
          0: if (bidx >= TGT) begin
               if (p == 8'h75) ds = 1;
               else if (!(bidx == TGT && p == 8'h00)) ds = 9;
             end
          1: if (p == 8'h90) ds = 2; else if (f == 8'h02) ds = 3; else ds = 9;
          2: begin pend_val = p; pend_at = bidx + 2; ds = 9; end
          3: begin pend_val = 8'h5A; pend_at = bidx + 2; ds = 9; end
          default: ;
        endcase
        if (bidx == pend_at) port_val_i <= pend_val;
        bidx = bidx + 1;
      end
    end
  end

  // per-clock reference checks
  int  nsub = 3, opaddr = TGT + 2, wr_idx = 0, trials = 0, gap = 0;
  bit  first = 1'b1, prev_rst = 1'b1, running = 1'b0;
  always @(negedge clk) begin
    if (!rst && running) begin
      if (bus_cyc_i && !cpu_rst_o)  // R3 window
        chk(ovr_en_o == (bidx >= TGT && bidx < TGT + nsub), "R3 ovr_en", ovr_en_o,
            (bidx >= TGT && bidx < TGT + nsub));
      if (cpu_rst_o && !prev_rst) begin
        trials++;
        chk(bidx == TGT + nsub + OBS, "R2 strobes per trial", bidx, TGT + nsub + OBS);
        gap = 0;
      end
      if (cpu_rst_o) gap++;
      if (!cpu_rst_o && prev_rst) begin
        if (!first) chk(gap == RST_CYC + 2, "R2 reset gap", gap, RST_CYC + 2);
        first = 1'b0;
      end
      if (tbl_we_o) begin
        chk(tbl_addr_o == 8'(wr_idx), "R8 table addr", tbl_addr_o, wr_idx);
        chk(tbl_data_o == (tbl_addr_o ^ key(opaddr)), "R5 R8 table data", tbl_data_o,
            tbl_addr_o ^ key(opaddr));
        wr_idx++;
      end
    end
    prev_rst = cpu_rst_o;
  end

  task automatic run(input logic [15:0] seed, input bit pfx, input logic [7:0] pb,
                     input bit exp_ok, input int exp_trials, input bit poke);
    int hold;
    nsub = pfx ? 4 : 3; opaddr = TGT + nsub - 1;
    wr_idx = 0; trials = 0; first = 1'b1; running = 1'b1; hold = 0;
    @(negedge clk);
    seed_i = seed; pfx_en_i = pfx; pfx_byte_i = pb; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    while (!done_o) begin
      @(negedge clk);
      if (poke && wr_idx == 100 && hold == 0) hold = 300;
      if (hold > 1) begin start_i = 1'b1; seed_i = 16'hFFF0; hold--; end
      else start_i = 1'b0;
    end
    @(negedge clk);
    chk(ok_o == exp_ok, exp_ok ? "R8 ok" : "R7 ok", ok_o, exp_ok);
    chk(wr_idx == (exp_ok ? 256 : 0), exp_ok ? "R8 write count" : "R7 no writes",
        wr_idx, exp_ok ? 256 : 0);
    chk(trials == exp_trials, "R6 trial count", trials, exp_trials);
    repeat (40) @(negedge clk);
    chk(done_o == 1'b1, "R10 done held", done_o, 1);
    running = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk(cpu_rst_o == 1'b1, "R1 cpu_rst", cpu_rst_o, 1);
    chk({ovr_en_o, tbl_we_o, done_o, ok_o} == 4'b0, "R1 outputs",
        {ovr_en_o, tbl_we_o, done_o, ok_o}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(cpu_rst_o == 1'b1 && done_o == 1'b0, "R1 after release", {cpu_rst_o, done_o}, 2);
    // R4 R6 R10: pairs 0000..0076, decoy 0002 rejected, start held mid-table
    run(16'h0000, 1'b0, 8'h00, 1'b1, 8'h77 + 2 + 256, 1'b1);
    // R7: candidates FFF0..FFFF all fail
    run(16'hFFF0, 1'b0, 8'h00, 1'b0, 16, 1'b0);
    // R9: prefix, seed from known ciphertexts at the following addresses
    run(16'h93C3, 1'b1, 8'h75, 1'b1, 2 + 256, 1'b0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual %0d expected %0d", 190000, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule